// File: doc/BRIEF.md
# DMA Channel Interrupt Status Word

This block gathers event and fault indications from a set of receive and transmit DMA channel engines and presents them as one read-only status word. Each channel owns an 8-bit group in the word. Six bits in each group latch single-cycle event pulses from the channel's engine. These record the end-of-packet cause (count threshold or timer), any completed packet, a descriptor interrupt, a read that returned error-marked data, and one extra fault. On a receive channel the extra fault is a packet dropped for lack of descriptors. On a transmit channel it is a malformed descriptor chain. The other two bits of each group are live watermark comparisons of the channel's descriptor count, and they are never stored.

A bus read, marked by a one-cycle strobe, returns the word and clears every latched bit at the end of that cycle. An event that arrives in the same cycle as the read is kept, so no event is lost. Certain faults also set a sticky per-channel halt that is sent back to the engine. The halt stays set until the channel's enable is dropped, so software must disable and then re-enable the channel to restart it. A single interrupt line is the OR of the latched bits, each gated by its own mask bit.

Top module: `dma_irq_status`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, every latched status bit, every halt output and the interrupt output are 0.
- R2: When the read strobe is high in a cycle, every latched bit reads 0 from the next cycle on, unless a new event pulse sets it.
- R3: Channel group i occupies status bits 8i+7..8i. Receive channels come first, then transmit channels (default order rx0, rx1, tx0, tx1). A one-cycle event pulse sets its bit from the next cycle until a read. The bits are: count-threshold EOP at bit 0, timer EOP at bit 1, packet done at bit 2, descriptor interrupt at bit 3, read data error at bit 6, and extra fault at bit 7.
- R4: An event pulse that coincides with a read strobe leaves its bit set after the read.
- R5: Bit 4 of a group is 1 exactly when the channel's descriptor count is below its high mark. Bit 5 is 1 exactly when the count is below its low mark. Both follow their inputs in the same cycle and are not affected by reads.
- R6: A read-error pulse on an enabled channel sets that channel's halt output from the next cycle. The halt is not cleared by reads and holds while the channel stays enabled. It clears on the cycle after the enable is seen low. A fault pulse on a disabled channel does not set the halt.
- R7: An extra-fault pulse halts a transmit channel, as in R6, but does not halt a receive channel. In both cases it sets status bit 7.
- R8: The interrupt output is the OR, over all latched bits, of the bit ANDed with the same-index mask bit. The live watermark bits never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle read of the status word; clears latched bits |
| ev_cnt | input | NCH | Per-channel EOP pulse, packet count threshold reached |
| ev_tmr | input | NCH | Per-channel EOP pulse, packet timer fired |
| ev_pkt | input | NCH | Per-channel pulse at the end of any packet |
| ev_dsc | input | NCH | Per-channel pulse, descriptor with interrupt flag |
| ev_err | input | NCH | Per-channel pulse, read returned error-marked data |
| ev_aux | input | NCH | Per-channel extra fault (rx: drop, tx: bad descriptor chain) |
| chan_en | input | NCH | Per-channel enable; low clears the halt |
| desc_cnt | input | NCH*DW | Current descriptor count per channel |
| hi_mark | input | NCH*DW | High watermark per channel |
| lo_mark | input | NCH*DW | Low watermark per channel |
| irq_mask | input | 8*NCH | Per-bit interrupt enable |
| stat_q | output | 8*NCH | Status word |
| halted | output | NCH | Per-channel stop indication to the engine |
| irq | output | 1 | Masked OR of latched bits |

## Verification
The bench targets an event that lands in the same cycle as a read. A design that gives the clear priority would lose that event, and the bit would read 0 afterwards. It sets watermark counts equal to the mark, where an off-by-one compare (`<=` instead of `<`) shows up, and it reads while the watermark bits are set, which exposes a design that latches or clears them. It drives extra faults on both receive and transmit channels to catch a halt applied to the wrong kind. It holds a halted channel enabled across reads, then drops the enable, so a halt that is released too early, cleared by a read, or never released is caught.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    localparam int GRP_W = 8;

    // Live (unlatched) positions inside one channel group
    localparam logic [GRP_W-1:0] LIVE_MASK = 8'b0011_0000;

    typedef enum logic {
        CH_RX = 1'b0,
        CH_TX = 1'b1
    } ch_kind_e;

    // One channel group, MSB first so cnt_hit lands on bit 0
    typedef struct packed {
        logic aux_fault;
        logic rd_err;
        logic below_lo;
        logic below_hi;
        logic desc_irq;
        logic pkt_done;
        logic tmr_hit;
        logic cnt_hit;
    } grp_t;

    // Event pulses arriving from one engine in one cycle
    typedef struct packed {
        logic cnt_hit;
        logic tmr_hit;
        logic pkt_done;
        logic desc_irq;
        logic rd_err;
        logic aux_fault;
    } ev_t;

    function automatic ch_kind_e kind_of(input int idx, input int nrx);
        return (idx < nrx) ? CH_RX : CH_TX;
    endfunction

    function automatic logic [GRP_W*32-1:0] latch_mask_of(input int nch);
        logic [GRP_W*32-1:0] m;
        m = '0;
        for (int c = 0; c < nch; c++) begin
            m[c*GRP_W +: GRP_W] = ~LIVE_MASK;
        end
        return m;
    endfunction

endpackage

// File: rtl/dma_stat_wm.sv
module dma_stat_wm #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    output logic          below_hi,
    output logic          below_lo
);
    // Live comparison only, never stored
    always_comb begin
        below_hi = (cnt < hi);
        below_lo = (cnt < lo);
    end
endmodule

// File: rtl/dma_stat_chan.sv
module dma_stat_chan
    import dma_stat_pkg::*;
#(
    parameter ch_kind_e KIND = CH_RX
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_clr,
    input  logic chan_en,
    input  ev_t  ev,
    output grp_t flags,
    output logic halt
);
    grp_t lat_q;
    grp_t lat_d;
    logic halt_q;
    logic halt_d;
    logic stop_req;

    // Which faults stop the channel depends on its direction
    generate
        if (KIND == CH_TX) begin : g_tx_stop
            assign stop_req = ev.rd_err | ev.aux_fault;
        end else begin : g_rx_stop
            assign stop_req = ev.rd_err;
        end
    endgenerate

    // Read clears first, then new pulses are merged so none is lost
    always_comb begin
        lat_d           = rd_clr ? '0 : lat_q;
        lat_d.cnt_hit   = lat_d.cnt_hit   | ev.cnt_hit;
        lat_d.tmr_hit   = lat_d.tmr_hit   | ev.tmr_hit;
        lat_d.pkt_done  = lat_d.pkt_done  | ev.pkt_done;
        lat_d.desc_irq  = lat_d.desc_irq  | ev.desc_irq;
        lat_d.rd_err    = lat_d.rd_err    | ev.rd_err;
        lat_d.aux_fault = lat_d.aux_fault | ev.aux_fault;
        lat_d.below_hi  = 1'b0;
        lat_d.below_lo  = 1'b0;
    end

    // Sticky halt: only a disable releases it
    always_comb begin
        if (!chan_en) begin
            halt_d = 1'b0;
        end else if (stop_req) begin
            halt_d = 1'b1;
        end else begin
            halt_d = halt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q  <= '0;
            halt_q <= 1'b0;
        end else begin
            lat_q  <= lat_d;
            halt_q <= halt_d;
        end
    end

    assign flags = lat_q;
    assign halt  = halt_q;
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_stat_pkg::*;
#(
    parameter int NRX = 2,
    parameter int NTX = 2,
    parameter int DW  = 8,
    localparam int NCH = NRX + NTX,
    localparam int SW  = NCH * GRP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [NCH-1:0]    ev_cnt,
    input  logic [NCH-1:0]    ev_tmr,
    input  logic [NCH-1:0]    ev_pkt,
    input  logic [NCH-1:0]    ev_dsc,
    input  logic [NCH-1:0]    ev_err,
    input  logic [NCH-1:0]    ev_aux,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*DW-1:0] desc_cnt,
    input  logic [NCH*DW-1:0] hi_mark,
    input  logic [NCH*DW-1:0] lo_mark,
    input  logic [SW-1:0]     irq_mask,
    output logic [SW-1:0]     stat_q,
    output logic [NCH-1:0]    halted,
    output logic              irq
);
    logic [SW-1:0] lat_vec;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            ev_t  ev;
            grp_t flags;
            grp_t word;
            logic b_hi;
            logic b_lo;

            assign ev = '{cnt_hit:   ev_cnt[c],
                          tmr_hit:   ev_tmr[c],
                          pkt_done:  ev_pkt[c],
                          desc_irq:  ev_dsc[c],
                          rd_err:    ev_err[c],
                          aux_fault: ev_aux[c]};

            dma_stat_chan #(
                .KIND(kind_of(c, NRX))
            ) u_chan (
                .clk     (clk),
                .rst     (rst),
                .rd_clr  (rd_stb),
                .chan_en (chan_en[c]),
                .ev      (ev),
                .flags   (flags),
                .halt    (halted[c])
            );

            dma_stat_wm #(
                .DW(DW)
            ) u_wm (
                .cnt      (desc_cnt[c*DW +: DW]),
                .hi       (hi_mark[c*DW +: DW]),
                .lo       (lo_mark[c*DW +: DW]),
                .below_hi (b_hi),
                .below_lo (b_lo)
            );

            always_comb begin
                word          = flags;
                word.below_hi = b_hi;
                word.below_lo = b_lo;
            end

            assign stat_q[c*GRP_W +: GRP_W]  = word;
            assign lat_vec[c*GRP_W +: GRP_W] = flags & ~LIVE_MASK;
        end
    endgenerate

    assign irq = |(lat_vec & irq_mask);
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int SW = NCH * 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_stb,
    input logic [NCH-1:0]    ev_cnt,
    input logic [NCH-1:0]    ev_tmr,
    input logic [NCH-1:0]    ev_pkt,
    input logic [NCH-1:0]    ev_dsc,
    input logic [NCH-1:0]    ev_err,
    input logic [NCH-1:0]    ev_aux,
    input logic [NCH-1:0]    chan_en,
    input logic [NCH*DW-1:0] desc_cnt,
    input logic [NCH*DW-1:0] hi_mark,
    input logic [NCH*DW-1:0] lo_mark,
    input logic [SW-1:0]     irq_mask,
    input logic [SW-1:0]     stat_q,
    input logic [NCH-1:0]    halted,
    input logic              irq
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && halted == '0));

    p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && ev_cnt == '0 && ev_tmr == '0 && ev_pkt == '0 &&
         ev_dsc == '0 && ev_err == '0 && ev_aux == '0) |=> !irq);

    p_unmasked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == '0) |-> !irq);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            p_pkt_sets_r3: assert property (@(posedge clk) disable iff (rst)
                ev_pkt[c] |=> stat_q[c*8 + 2]);

            p_keep_on_read_r4: assert property (@(posedge clk) disable iff (rst)
                (rd_stb && ev_tmr[c]) |=> stat_q[c*8 + 1]);

            p_wm_high_r5: assert property (@(posedge clk) disable iff (rst)
                stat_q[c*8 + 4] == (desc_cnt[c*DW +: DW] < hi_mark[c*DW +: DW]));

            p_wm_low_r5: assert property (@(posedge clk) disable iff (rst)
                stat_q[c*8 + 5] == (desc_cnt[c*DW +: DW] < lo_mark[c*DW +: DW]));

            p_err_halts_r6: assert property (@(posedge clk) disable iff (rst)
                (chan_en[c] && ev_err[c]) |=> halted[c]);

            p_halt_sticky_r6: assert property (@(posedge clk) disable iff (rst)
                (halted[c] && chan_en[c]) |=> halted[c]);

            p_halt_release_r6: assert property (@(posedge clk) disable iff (rst)
                !chan_en[c] |=> !halted[c]);

            p_aux_sets_r7: assert property (@(posedge clk) disable iff (rst)
                ev_aux[c] |=> stat_q[c*8 + 7]);
        end
    endgenerate
endmodule

bind dma_irq_status dma_irq_status_chk #(
    .NCH(NCH),
    .DW (DW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .ev_cnt   (ev_cnt),
    .ev_tmr   (ev_tmr),
    .ev_pkt   (ev_pkt),
    .ev_dsc   (ev_dsc),
    .ev_err   (ev_err),
    .ev_aux   (ev_aux),
    .chan_en  (chan_en),
    .desc_cnt (desc_cnt),
    .hi_mark  (hi_mark),
    .lo_mark  (lo_mark),
    .irq_mask (irq_mask),
    .stat_q   (stat_q),
    .halted   (halted),
    .irq      (irq)
);

// File: tb/dma_irq_status_tb_top.sv
`timescale 1ns/1ps
module dma_irq_status_tb_top;
    localparam int NCH = 4;
    localparam int NRX = 2;
    localparam int DW  = 8;
    localparam int SW  = NCH * 8;
    localparam logic [SW-1:0] LIVE = 32'h3030_3030;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_stb = 1'b0;
    logic [NCH-1:0]    ev_cnt = '0, ev_tmr = '0, ev_pkt = '0, ev_dsc = '0, ev_err = '0, ev_aux = '0;
    logic [NCH-1:0]    chan_en = '1;
    logic [NCH*DW-1:0] desc_cnt = '0, hi_mark = '0, lo_mark = '0;
    logic [SW-1:0]     irq_mask = '1;
    logic [SW-1:0]     stat_q;
    logic [NCH-1:0]    halted;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;
    int edges = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_lat [SW];
    bit m_halt [NCH];

    always #2.5 clk = ~clk;

    dma_irq_status #(.NRX(NRX), .NTX(NCH-NRX), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .rd_stb(rd_stb),
        .ev_cnt(ev_cnt), .ev_tmr(ev_tmr), .ev_pkt(ev_pkt), .ev_dsc(ev_dsc),
        .ev_err(ev_err), .ev_aux(ev_aux), .chan_en(chan_en),
        .desc_cnt(desc_cnt), .hi_mark(hi_mark), .lo_mark(lo_mark),
        .irq_mask(irq_mask), .stat_q(stat_q), .halted(halted), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference update at each rising edge
    always @(posedge clk) begin
        edges++;
        if (rst) begin
            for (int b = 0; b < SW; b++) m_lat[b] = 0;
            for (int c = 0; c < NCH; c++) m_halt[c] = 0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (rd_stb) begin
                    for (int k = 0; k < 8; k++) m_lat[c*8+k] = 0;
                end
                if (ev_cnt[c]) m_lat[c*8+0] = 1;
                if (ev_tmr[c]) m_lat[c*8+1] = 1;
                if (ev_pkt[c]) m_lat[c*8+2] = 1;
                if (ev_dsc[c]) m_lat[c*8+3] = 1;
                if (ev_err[c]) m_lat[c*8+6] = 1;
                if (ev_aux[c]) m_lat[c*8+7] = 1;
                if (!chan_en[c]) m_halt[c] = 0;
                else if (ev_err[c] || (c >= NRX && ev_aux[c])) m_halt[c] = 1;
            end
        end
    end

    // compare on every falling edge, before inputs move
    always @(negedge clk) begin
        if (edges > 0 && !finished) begin
            logic [SW-1:0] e_lat, e_live;
            logic [NCH-1:0] e_halt;
            for (int c = 0; c < NCH; c++) begin
                for (int k = 0; k < 8; k++) e_lat[c*8+k] = m_lat[c*8+k];
                e_live[c*8 +: 8] = '0;
                e_live[c*8+4] = desc_cnt[c*DW +: DW] < hi_mark[c*DW +: DW];
                e_live[c*8+5] = desc_cnt[c*DW +: DW] < lo_mark[c*DW +: DW];
                e_halt[c] = m_halt[c];
            end
            check("R3 latched bits", 64'(stat_q & ~LIVE), 64'(e_lat));
            check("R5 live watermark", 64'(stat_q & LIVE), 64'(e_live));
            check("R6 halted", 64'(halted), 64'(e_halt));
            check("R8 irq", 64'(irq), 64'(|(e_lat & irq_mask)));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        rd_stb = 0;
        ev_cnt = '0; ev_tmr = '0; ev_pkt = '0; ev_dsc = '0; ev_err = '0; ev_aux = '0;
    endtask

    task automatic finish_up();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        idle();
        desc_cnt = {8'd3, 8'd3, 8'd3, 8'd3};
        hi_mark  = {8'd4, 8'd2, 8'd4, 8'd2};
        lo_mark  = {8'd1, 8'd9, 8'd1, 8'd9};
        repeat (4) tick();
        ev_pkt = '1; ev_err = '1;
        tick();
        check("R1 latched in reset", 64'(stat_q & ~LIVE), 64'd0);
        check("R1 halted in reset", 64'(halted), 64'd0);
        idle();
        rst = 0;
        tick();
        check("R1 irq after reset", 64'(irq), 64'd0);

        // R3: timer EOP on tx0 lands on bit 17
        ev_tmr[2] = 1; tick(); idle();
        check("R3 tx0 timer bit", 64'(stat_q[17]), 64'd1);
        ev_dsc[1] = 1; ev_cnt[3] = 1; tick(); idle();
        check("R3 rx1 dscr bit", 64'(stat_q[11]), 64'd1);
        check("R3 tx1 count bit", 64'(stat_q[24]), 64'd1);

        // R2: read clears
        rd_stb = 1; tick(); idle();
        check("R2 cleared", 64'(stat_q & ~LIVE), 64'd0);
        check("R2 irq low", 64'(irq), 64'd0);

        // R4: event with read survives
        ev_pkt[1] = 1; rd_stb = 1; tick(); idle();
        check("R4 event kept", 64'(stat_q[10]), 64'd1);
        rd_stb = 1; tick(); idle();

        // R5: equality edge and immunity to reads
        desc_cnt[7:0] = 8'd5; hi_mark[7:0] = 8'd5; lo_mark[7:0] = 8'd6;
        #1;
        check("R5 equal to high", 64'(stat_q[4]), 64'd0);
        check("R5 below low", 64'(stat_q[5]), 64'd1);
        rd_stb = 1; tick(); idle();
        check("R5 after read", 64'(stat_q[5:4]), 64'b10);

        // R8: mask gating
        irq_mask = '0;
        ev_dsc[0] = 1; tick(); idle();
        check("R8 masked", 64'(irq), 64'd0);
        irq_mask[3] = 1; #1;
        check("R8 unmasked", 64'(irq), 64'd1);
        irq_mask = LIVE; #1;
        check("R8 live excluded", 64'(irq), 64'd0);
        irq_mask = '1;
        rd_stb = 1; tick(); idle();

        // R6: halt lifecycle
        ev_err[1] = 1; tick(); idle();
        check("R6 halt set", 64'(halted[1]), 64'd1);
        rd_stb = 1; tick(); idle(); tick();
        check("R6 halt survives read", 64'(halted[1]), 64'd1);
        chan_en[1] = 0; ev_err[1] = 1; tick(); idle();
        check("R6 halt released", 64'(halted[1]), 64'd0);
        chan_en[1] = 1; tick();
        check("R6 stays released", 64'(halted[1]), 64'd0);

        // R7: extra fault halts only tx
        ev_aux[0] = 1; ev_aux[3] = 1; tick(); idle();
        check("R7 rx no halt", 64'(halted[0]), 64'd0);
        check("R7 tx halt", 64'(halted[3]), 64'd1);
        check("R7 rx bit", 64'(stat_q[7]), 64'd1);
        chan_en[3] = 0; tick(); chan_en[3] = 1;
        rd_stb = 1; tick(); idle();

        // random traffic against the reference
        for (int i = 0; i < 4000; i++) begin
            for (int c = 0; c < NCH; c++) begin
                ev_cnt[c] = ($urandom % 8) == 0;
                ev_tmr[c] = ($urandom % 8) == 0;
                ev_pkt[c] = ($urandom % 4) == 0;
                ev_dsc[c] = ($urandom % 8) == 0;
                ev_err[c] = ($urandom % 40) == 0;
                ev_aux[c] = ($urandom % 40) == 0;
                if (($urandom % 30) == 0) chan_en[c] = ~chan_en[c];
                desc_cnt[c*DW +: DW] = DW'($urandom % 12);
                hi_mark[c*DW +: DW]  = DW'($urandom % 12);
                lo_mark[c*DW +: DW]  = DW'($urandom % 12);
            end
            rd_stb = ($urandom % 5) == 0;
            if (($urandom % 50) == 0) irq_mask = $urandom;
            tick();
        end
        idle();
        tick();
        finish_up();
    end
endmodule